// File: doc/BRIEF.md
# Secure Countdown Timer Control with Privilege Gating

This block holds the control word of a secure physical countdown timer and produces the timer's level interrupt. It also decides whether a system-register access to that control word may proceed. Each access arrives as a one-cycle request. The request carries a read/write flag, a 64-bit write datum and a 16-bit packed register encoding. It is qualified by the current exception level and by three secure-configuration bits: the non-secure flag, the secure-hypervisor enable and the secure-timer access grant. An input also says whether the highest exception level exists.

Every access whose encoding matches gets exactly one of three answers, one cycle after the request: allowed, undefined, or trapped to the highest level with syndrome code 0x18. An allowed read returns the control word. An allowed write updates the two writable bits. The countdown source is a signed down-counter inside the block. It decrements on every clock and can be reloaded through a port. Disabling the timer silences the interrupt but does not stop the count.

Top module: `stpt_timer_ctl`

## Requirements
- R1: The block responds only when `acc_valid` is high and `acc_enc` equals the packed encoding {op0[1:0]=2'b11, op1[2:0]=3'b111, CRn[3:0]=4'b1110, CRm[3:0]=4'b0010, op2[2:0]=3'b001} = 16'hFF11, with op0 in the top bits. Any other encoding gives no response and leaves the control word unchanged.
- R2: A matching request in cycle t raises exactly one of `acc_ok`, `acc_undef` and `acc_trap` in cycle t+1, for one cycle.
- R3: When `el3_present` is 0, every access is undefined. Otherwise, accesses from level 0 and level 2 (`cur_el` 2'd0 and 2'd2) are undefined, and accesses from level 3 (2'd3) are allowed.
- R4: A level-1 access (2'd1) is resolved in this order. It is undefined if `scr_ns` is 1. It is undefined if `scr_eel2` is 1. It traps if `scr_st` is 0. Otherwise it is allowed.
- R5: `trap_syndrome` is 6'h18 in the cycle `acc_trap` is high and zero otherwise.
- R6: The control word has bit 0 = enable, bit 1 = interrupt mask and bit 2 = status. Bits 63:3 read as zero, and writes to them are ignored.
- R7: The status bit is read-only. It equals enable AND (counter <= 0 as a signed value), and it does not depend on the mask.
- R8: `timer_irq` is a register. It becomes 1 one cycle after enable=1, status=1 and mask=0 all hold, and it falls one cycle after any of these stops holding.
- R9: `tval_o` decrements by one on every clock, wraps from the most negative value to the most positive, loads `tval_load_val` when `tval_load` is high, and keeps counting while enable is 0.
- R10: An undefined or trapped access does not change the control word, and it returns `rd_data` of zero.
- R11: After reset, enable, mask, `timer_irq`, `tval_o` and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_enc | input | 16 | Packed register encoding {op0,op1,CRn,CRm,op2} |
| acc_wdata | input | 64 | Write datum |
| cur_el | input | 2 | Current exception level |
| el3_present | input | 1 | Highest exception level implemented |
| scr_ns | input | 1 | Non-secure state flag |
| scr_eel2 | input | 1 | Secure hypervisor level enabled |
| scr_st | input | 1 | Secure timer access granted to level 1 |
| tval_load | input | 1 | Load the countdown value |
| tval_load_val | input | CW | Value to load (signed) |
| tval_o | output | CW | Current countdown value (signed) |
| acc_ok | output | 1 | Access allowed and performed |
| acc_undef | output | 1 | Access undefined |
| acc_trap | output | 1 | Access trapped to the highest level |
| trap_syndrome | output | 6 | Trap code, 6'h18 when trapped |
| rd_data | output | 64 | Read data of an allowed read, else zero |
| timer_irq | output | 1 | Level timer interrupt |

## Verification
The hardest case to reach from the ports is a rejected write whose datum would visibly have changed the control word. The bench first sets a known control word through a level-3 write. It then applies an all-ones write under every combination of level, level-3 presence and the three configuration bits, and reads the word back at level 3. Any leak from a rejected access shows up in that read-back. The interrupt's one-cycle lag is reached by loading a small positive count with the timer enabled and sampling on each cycle as the count crosses zero.

// File: rtl/stpt_pkg.sv
`timescale 1ns/1ps
package stpt_pkg;

    localparam int REG_W = 64;
    localparam int ENC_W = 16;
    localparam int SYN_W = 6;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } exc_level_e;

    typedef enum logic [1:0] {
        GATE_ALLOW = 2'd0,
        GATE_UNDEF = 2'd1,
        GATE_TRAP  = 2'd2
    } gate_e;

    typedef struct packed {
        logic [1:0] op0;
        logic [2:0] op1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op2;
    } sysreg_enc_t;

    localparam sysreg_enc_t CTL_ENC = '{op0: 2'b11, op1: 3'b111, crn: 4'b1110,
                                        crm: 4'b0010, op2: 3'b001};

    localparam logic [SYN_W-1:0] TRAP_SYNDROME = 6'h18;

    typedef struct packed {
        logic imask;
        logic enable;
    } ctl_t;

    // Privilege decision; the order of the tests sets priority.
    function automatic gate_e classify(exc_level_e el, logic el3_present,
                                       logic ns, logic eel2, logic st);
        gate_e g;
        g = GATE_UNDEF;
        if (el3_present) begin
            case (el)
                LVL3:    g = GATE_ALLOW;
                LVL1: begin
                    if (ns)        g = GATE_UNDEF;
                    else if (eel2) g = GATE_UNDEF;
                    else if (!st)  g = GATE_TRAP;
                    else           g = GATE_ALLOW;
                end
                default: g = GATE_UNDEF;
            endcase
        end
        return g;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(ctl_t c, logic istatus);
        logic [REG_W-1:0] r;
        r    = '0;
        r[0] = c.enable;
        r[1] = c.imask;
        r[2] = istatus;
        return r;
    endfunction

    function automatic ctl_t unpack_ctl(logic [REG_W-1:0] d);
        ctl_t c;
        c.enable = d[0];
        c.imask  = d[1];
        return c;
    endfunction

endpackage

// File: rtl/stpt_access_gate.sv
`timescale 1ns/1ps
module stpt_access_gate
    import stpt_pkg::*;
(
    input  logic [1:0] cur_el,
    input  logic       el3_present,
    input  logic       scr_ns,
    input  logic       scr_eel2,
    input  logic       scr_st,
    output gate_e      gate
);

    always_comb begin
        gate = classify(exc_level_e'(cur_el), el3_present, scr_ns, scr_eel2, scr_st);
    end

endmodule

// File: rtl/stpt_downcounter.sv
`timescale 1ns/1ps
module stpt_downcounter #(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [CW-1:0] load_val,
    output logic signed [CW-1:0] value
);

    localparam logic signed [CW-1:0] STEP = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else begin
            value <= value - STEP;
        end
    end

endmodule

// File: rtl/stpt_ctl_reg.sv
`timescale 1ns/1ps
module stpt_ctl_reg
    import stpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  ctl_t                 wr_ctl,
    input  logic signed [CW-1:0] tval,
    output ctl_t                 ctl,
    output logic                 istatus,
    output logic                 irq
);

    logic cond_met;

    always_comb begin
        cond_met = tval[CW-1] || (tval == '0);
        istatus  = ctl.enable && cond_met;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            irq <= 1'b0;
        end else begin
            if (wr_en) begin
                ctl <= wr_ctl;
            end
            irq <= ctl.enable && istatus && !ctl.imask;
        end
    end

endmodule

// File: rtl/stpt_timer_ctl.sv
`timescale 1ns/1ps
module stpt_timer_ctl
    import stpt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ENC_W-1:0]     acc_enc,
    input  logic [REG_W-1:0]     acc_wdata,
    input  logic [1:0]           cur_el,
    input  logic                 el3_present,
    input  logic                 scr_ns,
    input  logic                 scr_eel2,
    input  logic                 scr_st,
    input  logic                 tval_load,
    input  logic signed [CW-1:0] tval_load_val,
    output logic signed [CW-1:0] tval_o,
    output logic                 acc_ok,
    output logic                 acc_undef,
    output logic                 acc_trap,
    output logic [SYN_W-1:0]     trap_syndrome,
    output logic [REG_W-1:0]     rd_data,
    output logic                 timer_irq
);

    gate_e gate;
    ctl_t  ctl;
    logic  istatus;
    logic  enc_hit;
    logic  grant;
    logic  wr_en;
    logic  ctl_en;
    logic  ctl_im;

    stpt_access_gate u_gate (
        .cur_el      (cur_el),
        .el3_present (el3_present),
        .scr_ns      (scr_ns),
        .scr_eel2    (scr_eel2),
        .scr_st      (scr_st),
        .gate        (gate)
    );

    stpt_downcounter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (tval_load),
        .load_val (tval_load_val),
        .value    (tval_o)
    );

    always_comb begin
        enc_hit = acc_valid && (acc_enc == CTL_ENC);
        grant   = enc_hit && (gate == GATE_ALLOW);
        wr_en   = grant && acc_write;
        ctl_en  = ctl.enable;
        ctl_im  = ctl.imask;
    end

    stpt_ctl_reg #(.CW(CW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ctl  (unpack_ctl(acc_wdata)),
        .tval    (tval_o),
        .ctl     (ctl),
        .istatus (istatus),
        .irq     (timer_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_ok        <= 1'b0;
            acc_undef     <= 1'b0;
            acc_trap      <= 1'b0;
            trap_syndrome <= '0;
            rd_data       <= '0;
        end else begin
            acc_ok        <= grant;
            acc_undef     <= enc_hit && (gate == GATE_UNDEF);
            acc_trap      <= enc_hit && (gate == GATE_TRAP);
            trap_syndrome <= (enc_hit && (gate == GATE_TRAP)) ? TRAP_SYNDROME : '0;
            rd_data       <= (grant && !acc_write) ? pack_ctl(ctl, istatus) : '0;
        end
    end

endmodule

// File: rtl/stpt_timer_ctl_chk.sv
`timescale 1ns/1ps
module stpt_timer_ctl_chk
    import stpt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_valid,
    input logic [ENC_W-1:0]     acc_enc,
    input logic [1:0]           cur_el,
    input logic                 el3_present,
    input logic                 tval_load,
    input logic signed [CW-1:0] tval_o,
    input logic                 acc_ok,
    input logic                 acc_undef,
    input logic                 acc_trap,
    input logic [SYN_W-1:0]     trap_syndrome,
    input logic [REG_W-1:0]     rd_data,
    input logic                 timer_irq,
    input logic                 ctl_en,
    input logic                 ctl_im,
    input logic                 istatus
);

    assert_no_resp_on_miss_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_enc != CTL_ENC) |=> !(acc_ok || acc_undef || acc_trap));

    assert_single_answer_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc_ok, acc_undef, acc_trap}));

    assert_hit_answered_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_enc == CTL_ENC) |=> (acc_ok || acc_undef || acc_trap));

    assert_low_levels_undef_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_enc == CTL_ENC && (cur_el == 2'd0 || cur_el == 2'd2))
        |=> acc_undef);

    assert_top_level_ok_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_enc == CTL_ENC && cur_el == 2'd3 && el3_present)
        |=> acc_ok);

    assert_trap_code_R5: assert property (@(posedge clk) disable iff (rst)
        acc_trap |-> trap_syndrome == 6'h18);

    assert_code_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !acc_trap |-> trap_syndrome == '0);

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:3] == '0);

    assert_status_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        istatus |-> ctl_en);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
        timer_irq == $past(ctl_en && istatus && !ctl_im));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tval_load)) |-> tval_o == $past(tval_o) - CW'(1));

    assert_reject_keeps_ctl_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_undef || acc_trap) |-> {ctl_en, ctl_im} == $past({ctl_en, ctl_im}));

    assert_reject_zero_data_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_undef || acc_trap) |-> rd_data == '0);

endmodule

bind stpt_timer_ctl stpt_timer_ctl_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .acc_valid     (acc_valid),
    .acc_enc       (acc_enc),
    .cur_el        (cur_el),
    .el3_present   (el3_present),
    .tval_load     (tval_load),
    .tval_o        (tval_o),
    .acc_ok        (acc_ok),
    .acc_undef     (acc_undef),
    .acc_trap      (acc_trap),
    .trap_syndrome (trap_syndrome),
    .rd_data       (rd_data),
    .timer_irq     (timer_irq),
    .ctl_en        (ctl_en),
    .ctl_im        (ctl_im),
    .istatus       (istatus)
);

// File: tb/tb_stpt_timer_ctl.sv
`timescale 1ns/1ps
module tb_stpt_timer_ctl;

    localparam int  CW      = 16;
    localparam time CLK_P   = 10ns;
    localparam logic [15:0] ENC = {2'b11, 3'b111, 4'b1110, 4'b0010, 3'b001};

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 acc_valid, acc_write;
    logic [15:0]          acc_enc;
    logic [63:0]          acc_wdata;
    logic [1:0]           cur_el;
    logic                 el3_present, scr_ns, scr_eel2, scr_st;
    logic                 tval_load;
    logic signed [CW-1:0] tval_load_val;
    logic signed [CW-1:0] tval_o;
    logic                 acc_ok, acc_undef, acc_trap;
    logic [5:0]           trap_syndrome;
    logic [63:0]          rd_data;
    logic                 timer_irq;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_P/2) clk = ~clk;

    stpt_timer_ctl #(.CW(CW)) dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_enc(acc_enc), .acc_wdata(acc_wdata), .cur_el(cur_el),
        .el3_present(el3_present), .scr_ns(scr_ns), .scr_eel2(scr_eel2),
        .scr_st(scr_st), .tval_load(tval_load), .tval_load_val(tval_load_val),
        .tval_o(tval_o), .acc_ok(acc_ok), .acc_undef(acc_undef),
        .acc_trap(acc_trap), .trap_syndrome(trap_syndrome), .rd_data(rd_data),
        .timer_irq(timer_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 allowed, 1 undefined, 2 trapped
    function automatic int exp_gate(int el, bit pres, bit ns, bit eel2, bit st);
        if (!pres) return 1;
        if (el == 3) return 0;
        if (el != 1) return 1;
        if (ns || eel2) return 1;
        if (!st) return 2;
        return 0;
    endfunction

    task automatic access(input int el, input bit pres, input bit ns, input bit eel2,
                          input bit st, input bit wr, input logic [63:0] wd,
                          input logic [15:0] enc, output logic [2:0] kind,
                          output logic [5:0] syn, output logic [63:0] rd);
        @(negedge clk);
        acc_valid   = 1'b1;
        acc_write   = wr;
        acc_wdata   = wd;
        acc_enc     = enc;
        cur_el      = el[1:0];
        el3_present = pres;
        scr_ns      = ns;
        scr_eel2    = eel2;
        scr_st      = st;
        @(negedge clk);
        kind = {acc_trap, acc_undef, acc_ok};
        syn  = trap_syndrome;
        rd   = rd_data;
        acc_valid = 1'b0;
    endtask

    task automatic top_write(input logic [63:0] wd);
        logic [2:0] k; logic [5:0] s; logic [63:0] r;
        access(3, 1, 0, 0, 0, 1, wd, ENC, k, s, r);
    endtask

    task automatic top_read(output logic [63:0] rd);
        logic [2:0] k; logic [5:0] s;
        access(3, 1, 0, 0, 0, 0, 64'h0, ENC, k, s, rd);
    endtask

    task automatic load(input logic signed [CW-1:0] v);
        @(negedge clk);
        tval_load = 1'b1;
        tval_load_val = v;
        @(negedge clk);
        tval_load = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [2:0]  k;
        logic [5:0]  s;
        logic [63:0] r;
        rst = 1'b1; acc_valid = 0; acc_write = 0; acc_enc = '0; acc_wdata = '0;
        cur_el = '0; el3_present = 0; scr_ns = 0; scr_eel2 = 0; scr_st = 0;
        tval_load = 0; tval_load_val = '0;
        repeat (3) @(negedge clk);
        check("R11", "tval in reset", 64'(tval_o), 64'h0);
        check("R11", "irq in reset", 64'(timer_irq), 64'h0);
        check("R11", "response in reset", 64'({acc_ok, acc_undef, acc_trap}), 64'h0);
        rst = 1'b0;
        top_read(r);
        check("R11", "control after reset", r, 64'h0);

        // R9: counter keeps going while disabled; irq stays low
        top_write(64'h0);
        load(16'sd5);
        check("R9", "tval after load", 64'(tval_o), 64'(16'sd5));
        repeat (10) @(negedge clk);
        check("R9", "tval after 10 clocks disabled", 64'(tval_o), 64'(-16'sd5));
        check("R8", "irq while disabled", 64'(timer_irq), 64'h0);
        top_read(r);
        check("R7", "status while disabled", r, 64'h0);

        // R8: one cycle lag on enable
        top_write(64'h1);
        check("R8", "irq same cycle as enable", 64'(timer_irq), 64'h0);
        @(negedge clk);
        check("R8", "irq one cycle after enable", 64'(timer_irq), 64'h1);
        top_read(r);
        check("R7", "status enabled, count negative", r, 64'h5);
        top_write(64'h3);
        check("R8", "irq same cycle as mask", 64'(timer_irq), 64'h1);
        @(negedge clk);
        check("R8", "irq after mask", 64'(timer_irq), 64'h0);
        top_read(r);
        check("R7", "status ignores mask", r, 64'h7);

        // R8: zero crossing
        top_write(64'h1);
        load(16'sd1000);
        check("R8", "irq lag on reload", 64'(timer_irq), 64'h1);
        @(negedge clk);
        check("R8", "irq after reload positive", 64'(timer_irq), 64'h0);
        load(16'sd2);
        for (int i = 0; i < 5; i++) begin
            int prev;
            prev = 2 - (i - 1);
            check("R9", "crossing count", 64'(tval_o), 64'(CW'(2 - i)));
            check("R8", "crossing irq", 64'(timer_irq),
                  64'((i >= 1 && prev <= 0) ? 1 : 0));
            @(negedge clk);
        end

        // R9: wrap
        load(16'sh8000);
        check("R9", "most negative", 64'(tval_o), 64'(16'sh8000));
        @(negedge clk);
        check("R9", "wrap to most positive", 64'(tval_o), 64'(16'sh7FFF));

        // R6/R7/R8: all written bit patterns, both count signs
        for (int sgn = 0; sgn < 2; sgn++) begin
            for (int v = 0; v < 8; v++) begin
                bit en, im, neg;
                load(sgn ? -16'sd10000 : 16'sd10000);
                top_write(64'hFFFF_FFFF_FFFF_FFF8 | 64'(v));
                top_read(r);
                en = v[0]; im = v[1]; neg = (sgn == 1);
                check("R6", "control read-back", r, {61'b0, en && neg, im, en});
                check("R8", "irq for pattern", 64'(timer_irq), 64'(en && neg && !im));
            end
        end

        // R1: every single-bit encoding mismatch is ignored
        top_write(64'h2);
        for (int b = 0; b < 16; b++) begin
            access(3, 1, 0, 0, 0, 1, '1, ENC ^ (16'h1 << b), k, s, r);
            check("R1", "no response on mismatch", 64'(k), 64'h0);
        end
        top_read(r);
        check("R1", "control unchanged after mismatches", r, 64'h2);

        // R2-R5, R10: sweep of privilege configuration
        load(16'sd30000);
        for (int el = 0; el < 4; el++)
        for (int p = 0; p < 2; p++)
        for (int ns = 0; ns < 2; ns++)
        for (int e2 = 0; e2 < 2; e2++)
        for (int st = 0; st < 2; st++)
        for (int wr = 0; wr < 2; wr++) begin
            int g;
            logic [2:0] ek;
            g = exp_gate(el, p[0], ns[0], e2[0], st[0]);
            ek = (g == 0) ? 3'b001 : (g == 1) ? 3'b010 : 3'b100;
            top_write(64'h2);
            access(el, p[0], ns[0], e2[0], st[0], wr[0], '1, ENC, k, s, r);
            check(el == 1 ? "R4" : "R3", "access answer {trap,undef,ok}", 64'(k), 64'(ek));
            check("R5", "syndrome", 64'(s), (g == 2) ? 64'h18 : 64'h0);
            check("R10", "read data of access", r, (g == 0 && wr == 0) ? 64'h2 : 64'h0);
            top_read(r);
            check("R10", "control after access", r, (g == 0 && wr == 1) ? 64'h3 : 64'h2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule